// File: doc/BRIEF.md
# ADC serial port sequencer

This block is the device-side digital front end of a multichannel delta-sigma converter. It runs a conversion timer and presents each finished result as a 24-bit serial frame on a data-out pin. In the same frame it takes in an 8-bit channel word and an 8-bit configuration word on the data-in pin. The analog modulator and the filter arithmetic are not part of the block. The finished result arrives as a plain input word and is captured when the conversion timer expires.

The host clocks the frame with an external serial clock while chip select is low. If the host raises chip select before the frame is complete, the frame ends at once and a new conversion starts. A word shifted in during that frame takes effect only if its last falling clock edge has already occurred. The serial clock level seen when the power-on hold-off ends selects the clocking mode. If that level is high, the block drives the serial clock itself and runs conversions and frames back to back, with chip select held low.

The frame is sent most significant bit first. The first bit is an end-of-conversion flag, driven 0 when a result is ready. The second bit is a fixed 0, and the remaining 22 bits carry the result input, sign bit first.

Top module: `adc_serial_seq`

## Requirements
- R1: After reset, and until the first word is committed, `conv_chan` and `conv_cfg` are 0 and `conv_busy` is 0 during the power-on hold-off.
- R2: `POR_CYCLES` clocks after reset is released, the level of `sck_in` is latched. A 1 selects internal clocking, and `sck_oe` shows the latched mode from then on.
- R3: `sdo_oe` equals the inverse of `cs_n`. While a conversion runs and `cs_n` is low, `sdo` is 1.
- R4: A ready frame puts bit 23 first on `sdo` (0 = ready), then a 0, then `conv_data` from its MSB down. `sdo` advances on each falling SCK edge, and `sdi` is sampled on each rising SCK edge.
- R5: The 24th rising SCK edge of a frame starts a conversion. It also commits the channel word (the first 8 `sdi` bits, MSB first) and the configuration word (the next 8 bits).
- R6: A rising `cs_n` during a frame, after at least one rising SCK edge, ends the frame and starts a conversion. A rising `cs_n` before the first rising SCK edge starts nothing, and the result stays available.
- R7: An early end before the 8th falling SCK edge leaves both the channel and the configuration unchanged.
- R8: An early end after the 8th and before the 16th falling SCK edge commits the channel and keeps the old configuration.
- R9: An early end after the 16th falling SCK edge commits both words.
- R10: In internal mode, `sck_out` holds each level for `SCK_HALF` clocks during a frame (`SCK_HALF` at least 2). It stays high during a conversion, and frames repeat without host action.
- R11: `conv_busy` stays high for exactly `CONV_CYCLES` clocks per conversion, and `conv_data` is captured at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; starts the power-on hold-off |
| cs_n | input | 1 | Chip select, active low |
| sck_in | input | 1 | Serial clock from the host; also the mode strap |
| sdi | input | 1 | Serial data in |
| conv_data | input | 22 | Result word (sign and magnitude) from the converter core |
| sck_out | output | 1 | Generated serial clock in internal mode |
| sck_oe | output | 1 | Drive enable for `sck_out` (internal mode) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo`; low means high impedance |
| conv_busy | output | 1 | Conversion in progress |
| conv_chan | output | 8 | Committed channel word |
| conv_cfg | output | 8 | Committed configuration word |

## Verification
The assertions assume that `cs_n`, `sck_in` and `sdi` are synchronous to `clk`. They also assume that each SCK level lasts at least one clock, and that chip select never changes in the same clock as an SCK edge. The bench keeps within these limits in three ways. It changes every input on the falling clock edge, it holds each SCK level for three clocks, and it moves chip select only after a full SCK low phase. Early-end points are directed at 7, 8, 15, 16 and 24 clock pulses, and further points are drawn at random over 1 to 24.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    typedef enum logic [1:0] {
        ST_POR  = 2'd0,
        ST_CONV = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

    function automatic int bits_for(input int max_val);
        bits_for = (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/sp_edge_det.sv
module sp_edge_det #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise,
    output logic fall
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= INIT;
        else        prev_q <= prev_d;
    end

    assign rise = d & ~prev_q;
    assign fall = ~d & prev_q;

endmodule

// File: rtl/sp_int_sck.sv
module sp_int_sck
    import adc_sp_pkg::*;
#(
    parameter int SCK_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck
);

    localparam int HW = bits_for(SCK_HALF - 1);
    localparam logic [HW-1:0] HMAX = HW'(SCK_HALF - 1);
    localparam logic [HW-1:0] HONE = HW'(1);

    typedef struct packed {
        logic          sck;
        logic [HW-1:0] cnt;
    } gen_t;

    gen_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (!run) begin
            g_d.sck = 1'b1;
            g_d.cnt = '0;
        end else if (g_q.cnt == HMAX) begin
            g_d.cnt = '0;
            g_d.sck = ~g_q.sck;
        end else begin
            g_d.cnt = g_q.cnt + HONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{sck: 1'b1, cnt: '0};
        else        g_q <= g_d;
    end

    assign sck = g_q.sck;

    // R10: a level is held until the half-period count is reached
    a_r10_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && g_q.cnt != HMAX) |=> $stable(g_q.sck));

endmodule

// File: rtl/sp_conv_timer.sv
module sp_conv_timer
    import adc_sp_pkg::*;
#(
    parameter int CONV_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = bits_for(CONV_CYCLES - 1);
    localparam logic [CW-1:0] CLOAD = CW'(CONV_CYCLES - 1);
    localparam logic [CW-1:0] CONE  = CW'(1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign done = t_q.busy && (t_q.cnt == '0);

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CLOAD;
        end else if (done) begin
            t_d.busy = 1'b0;
        end else if (t_q.busy) begin
            t_d.cnt = t_q.cnt - CONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;

    // R11: the sequencer never restarts a running conversion
    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !t_q.busy);

    // R11: a running conversion cannot end before its count runs out
    a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.busy && t_q.cnt != '0) |=> t_q.busy);

endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
    import adc_sp_pkg::*;
#(
    parameter int FRAME_BITS  = 24,
    parameter int WORD_BITS   = 8,
    parameter int CONV_CYCLES = 200,
    parameter int POR_CYCLES  = 40,
    parameter int SCK_HALF    = 4,
    localparam int DATA_W     = FRAME_BITS - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_in,
    input  logic              sdi,
    input  logic [DATA_W-1:0] conv_data,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              conv_busy,
    output logic [WORD_BITS-1:0] conv_chan,
    output logic [WORD_BITS-1:0] conv_cfg
);

    localparam int CNT_W = bits_for(FRAME_BITS);
    localparam int PW    = bits_for(POR_CYCLES - 1);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CH_EDGE = CNT_W'(WORD_BITS);
    localparam logic [CNT_W-1:0] CF_EDGE = CNT_W'(2 * WORD_BITS);
    localparam logic [CNT_W-1:0] CH_LAST = CNT_W'(WORD_BITS - 1);
    localparam logic [CNT_W-1:0] CF_LAST = CNT_W'(2 * WORD_BITS - 1);
    localparam logic [CNT_W-1:0] FR_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [PW-1:0]    POR_END = PW'(POR_CYCLES - 1);
    localparam logic [PW-1:0]    POR_ONE = PW'(1);

    typedef struct packed {
        seq_state_e           st;
        logic [PW-1:0]        por_cnt;
        logic                 int_mode;
        logic                 cs_prev;
        logic [CNT_W-1:0]     rise_cnt;
        logic [CNT_W-1:0]     fall_cnt;
        logic [WORD_BITS-2:0] sr;
        logic [WORD_BITS-1:0] chan_stage;
        logic [WORD_BITS-1:0] cfg_stage;
        logic [WORD_BITS-1:0] chan;
        logic [WORD_BITS-1:0] cfg;
        logic [FRAME_BITS-1:0] frame;
    } seq_t;

    seq_t s_d, s_q;

    logic conv_go, conv_done;
    logic int_sck, int_run;
    logic sck_eff, sck_rise, sck_fall;
    logic cs_rise;
    logic [WORD_BITS-1:0] byte_in;
    logic sdo_bit;

    // serial clock source: host pin or local generator
    assign int_run = s_q.int_mode && (s_q.st == ST_DATA) && !cs_n;
    assign sck_eff = s_q.int_mode ? int_sck : sck_in;
    assign cs_rise = cs_n && !s_q.cs_prev;
    assign byte_in = {s_q.sr, sdi};

    sp_int_sck #(.SCK_HALF(SCK_HALF)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (int_run),
        .sck   (int_sck)
    );

    sp_edge_det #(.INIT(1'b1)) u_sck_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sck_eff),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    sp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_go),
        .busy  (conv_busy),
        .done  (conv_done)
    );

    always_comb begin
        s_d         = s_q;
        conv_go     = 1'b0;
        s_d.cs_prev = cs_n;
        case (s_q.st)
            ST_POR: begin
                if (s_q.por_cnt == POR_END) begin
                    s_d.int_mode = sck_in;
                    s_d.st       = ST_CONV;
                    conv_go      = 1'b1;
                end else begin
                    s_d.por_cnt = s_q.por_cnt + POR_ONE;
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    s_d.frame    = {2'b00, conv_data};
                    s_d.st       = ST_DATA;
                    s_d.rise_cnt = '0;
                    s_d.fall_cnt = '0;
                end
            end
            ST_DATA: begin
                if (cs_rise && s_q.rise_cnt != '0) begin
                    // early end: keep only words whose last bit has completed
                    if (s_q.fall_cnt >= CH_EDGE) s_d.chan = s_q.chan_stage;
                    if (s_q.fall_cnt >= CF_EDGE) s_d.cfg  = s_q.cfg_stage;
                    s_d.st  = ST_CONV;
                    conv_go = 1'b1;
                end else if (!cs_n) begin
                    if (sck_rise) begin
                        s_d.sr       = byte_in[WORD_BITS-2:0];
                        s_d.rise_cnt = s_q.rise_cnt + CNT_ONE;
                        if (s_q.rise_cnt == CH_LAST) s_d.chan_stage = byte_in;
                        if (s_q.rise_cnt == CF_LAST) s_d.cfg_stage  = byte_in;
                        if (s_q.rise_cnt == FR_LAST) begin
                            s_d.chan = s_d.chan_stage;
                            s_d.cfg  = s_d.cfg_stage;
                            s_d.st   = ST_CONV;
                            conv_go  = 1'b1;
                        end
                    end else if (sck_fall && s_q.fall_cnt < s_q.rise_cnt) begin
                        s_d.fall_cnt = s_q.fall_cnt + CNT_ONE;
                    end
                end
            end
            default: s_d.st = ST_POR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // output bit picked by the number of falling edges seen
    always_comb begin
        sdo_bit = 1'b1;
        if (s_q.st == ST_DATA) begin
            for (int i = 0; i < FRAME_BITS; i++) begin
                if (s_q.fall_cnt == CNT_W'(i)) sdo_bit = s_q.frame[FRAME_BITS-1-i];
            end
        end
    end

    assign sdo       = sdo_bit;
    assign sdo_oe    = ~cs_n;
    assign sck_out   = int_sck;
    assign sck_oe    = s_q.int_mode;
    assign conv_chan = s_q.chan;
    assign conv_cfg  = s_q.cfg;

    // R3: a running conversion shows not-ready on the data pin
    a_r3_busy_shows_high: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && !cs_n) |-> sdo);

    // R2: the mode latched at the end of the hold-off never changes
    a_r2_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_POR) |=> $stable(s_q.int_mode));

    // R5: the last rising edge of a frame launches a conversion
    a_r5_frame_end_converts: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DATA && !cs_n && sck_rise && s_q.rise_cnt == FR_LAST) |=> conv_busy);

    // R6: an early end launches a conversion
    a_r6_abort_converts: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DATA && cs_rise && s_q.rise_cnt != '0) |=> conv_busy);

    // R7: too few edges for the channel word leaves it alone
    a_r7_chan_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DATA && cs_rise && s_q.fall_cnt < CH_EDGE) |=> $stable(s_q.chan));

    // R8: too few edges for the configuration word leaves it alone
    a_r8_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DATA && cs_rise && s_q.fall_cnt < CF_EDGE) |=> $stable(s_q.cfg));

    // R9: a late early end commits both staged words
    a_r9_both_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DATA && cs_rise && s_q.rise_cnt != '0 && s_q.fall_cnt >= CF_EDGE)
        |=> (s_q.chan == $past(s_q.chan_stage) && s_q.cfg == $past(s_q.cfg_stage)));

    // R10: the generated clock rests high through a conversion
    a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(conv_busy) && conv_busy && s_q.int_mode) |-> sck_out);

endmodule

// File: tb/sim_adc_serial_seq.sv
module sim_adc_serial_seq;

    localparam int FB   = 24;
    localparam int DW   = FB - 2;
    localparam int CONV = 200;
    localparam int POR  = 40;
    localparam int SH   = 3;
    localparam int H    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck_in = 1'b0;
    logic sdi = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic sck_out, sck_oe, sdo, sdo_oe, conv_busy;
    logic [7:0] conv_chan, conv_cfg;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_ch = 8'h00;
    logic [7:0] exp_cf = 8'h00;
    logic [DW-1:0] exp_data = '0;

    always #2 clk = ~clk;

    adc_serial_seq #(
        .FRAME_BITS(FB), .WORD_BITS(8), .CONV_CYCLES(CONV),
        .POR_CYCLES(POR), .SCK_HALF(SH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_in(sck_in), .sdi(sdi),
        .conv_data(conv_data), .sck_out(sck_out), .sck_oe(sck_oe), .sdo(sdo),
        .sdo_oe(sdo_oe), .conv_busy(conv_busy), .conv_chan(conv_chan), .conv_cfg(conv_cfg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [FB-1:0] frame_of(input logic [DW-1:0] d);
        return {2'b00, d};
    endfunction

    function automatic logic chan_taken(input int k);
        return k >= 8;
    endfunction

    function automatic logic cfg_taken(input int k);
        return k >= 16;
    endfunction

    task automatic new_data();
        conv_data = DW'($urandom());
        exp_data  = conv_data;
    endtask

    task automatic do_reset(input logic sck_lvl, input logic cs_lvl);
        rst_n  = 1'b0;
        cs_n   = cs_lvl;
        sck_in = sck_lvl;
        sdi    = 1'b0;
        exp_ch = 8'h00;
        exp_cf = 8'h00;
        new_data();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_ready();
        int t;
        @(negedge clk);
        cs_n = 1'b0;
        t = 0;
        while (!(sdo === 1'b0 && conv_busy === 1'b0) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 2000) chk("R4 ready timeout", 32'd0, 32'd1);
    endtask

    // k full SCK pulses, then chip select rises
    task automatic host_frame(input int k, input logic [7:0] ch, input logic [7:0] cf);
        logic [15:0] inw;
        logic [FB-1:0] fexp;
        logic bad_bit;
        inw = {ch, cf};
        fexp = frame_of(exp_data);
        bad_bit = 1'b0;
        wait_ready();
        for (int p = 0; p < k; p++) begin
            @(negedge clk);
            if (sdo !== fexp[FB-1-p]) bad_bit = 1'b1;
            sdi = (p < 16) ? inw[15-p] : 1'($urandom());
            sck_in = 1'b1;
            repeat (H) @(negedge clk);
            sck_in = 1'b0;
            repeat (H - 1) @(negedge clk);
        end
        chk("R4 frame bits", {31'd0, bad_bit}, 32'd0);
        @(negedge clk);
        cs_n = 1'b1;
        new_data();
        if (chan_taken(k)) exp_ch = ch;
        if (cfg_taken(k))  exp_cf = cf;
        repeat (3) @(negedge clk);
        if (k == FB) chk("R5 full frame converts", conv_busy, 1);
        else         chk("R6 early end converts", conv_busy, 1);
        chk("R3 sdo released", sdo_oe, 0);
        if (k < 8)       chk("R7 channel kept", conv_chan, exp_ch);
        else if (k < 16) chk("R8 channel taken", conv_chan, exp_ch);
        else             chk("R9 channel taken", conv_chan, exp_ch);
        if (k < 16)      chk("R8 config kept", conv_cfg, exp_cf);
        else if (k < FB) chk("R9 config taken", conv_cfg, exp_cf);
        else             chk("R5 config taken", conv_cfg, exp_cf);
    endtask

    task automatic run_internal();
        int bits;
        int lows;
        int t;
        logic prev;
        logic [FB-1:0] got;
        do_reset(1'b1, 1'b0);
        repeat (POR + 3) @(negedge clk);
        chk("R2 internal mode", sck_oe, 1);
        chk("R3 busy shows high", sdo, 1);
        for (int f = 0; f < 2; f++) begin
            repeat (30) @(negedge clk);
            chk("R10 idle high", sck_out, 1);
            bits = 0; lows = 0; t = 0; got = '0;
            prev = sck_out;
            while (bits < FB && t < 5000) begin
                @(negedge clk);
                t++;
                if (sck_out == 1'b0) lows++;
                if (sck_out && !prev) begin
                    got[FB-1-bits] = sdo;
                    bits++;
                end
                prev = sck_out;
            end
            chk("R4 internal frame", got, frame_of(exp_data));
            chk("R10 half period", lows, FB * SH);
            @(negedge clk);
            chk("R10 next conversion", conv_busy, 1);
            new_data();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cnt;
        int k;
        void'($urandom(32'd4711));
        do_reset(1'b0, 1'b1);
        repeat (5) @(negedge clk);
        chk("R1 chan reset", conv_chan, 0);
        chk("R1 cfg reset", conv_cfg, 0);
        chk("R1 idle in hold-off", conv_busy, 0);
        chk("R3 sdo high-z", sdo_oe, 0);
        repeat (POR) @(negedge clk);
        chk("R2 external mode", sck_oe, 0);
        chk("R11 first conversion", conv_busy, 1);
        cs_n = 1'b0;
        @(negedge clk);
        chk("R3 busy shows high", sdo, 1);
        chk("R3 sdo driven", sdo_oe, 1);

        host_frame(7,  8'hA5, 8'h3C);
        host_frame(8,  8'h5A, 8'hC3);
        host_frame(15, 8'h17, 8'hE8);
        host_frame(16, 8'h81, 8'h7E);
        host_frame(24, 8'h42, 8'h99);

        // R6: chip select up before any clock edge
        wait_ready();
        @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R6 no conversion", conv_busy, 0);
        chk("R3 sdo high-z", sdo_oe, 0);
        host_frame(3, 8'hFF, 8'hFF);

        // R11: conversion length after a one-pulse early end
        wait_ready();
        @(negedge clk);
        sdi = 1'b1;
        sck_in = 1'b1;
        repeat (H) @(negedge clk);
        sck_in = 1'b0;
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        new_data();
        cnt = 0;
        for (int t = 0; t < 4 * CONV; t++) begin
            @(negedge clk);
            if (conv_busy) cnt++;
            else if (cnt > 0) break;
        end
        chk("R11 conversion length", cnt, CONV);
        chk("R7 channel kept", conv_chan, exp_ch);

        for (int r = 0; r < 20; r++) begin
            k = 1 + int'($urandom() % FB);
            host_frame(k, 8'($urandom()), 8'($urandom()));
        end

        run_internal();
        finish_run();
    end

endmodule